// File: doc/BRIEF.md
# Multi-Segment Gamma Evaluator

This block applies a piecewise-linear gamma curve to a stream of colour pixels, one channel per lane. Each lane keeps the curve in three tables of different resolution that nest inside one another. A very small table covers the darkest codes one input step at a time. A 256-point table covers the range up to 1/128. A 256-point table covers the full range, and a separate per-channel maximum register closes the curve at and beyond full scale. For every input the lane picks the finest table that covers the value and fetches the two points that bracket it. It then blends them by the input's remainder inside that step, so dark HDR-style curves keep detail that a uniform table would lose.

The pipeline takes a new pixel every cycle and returns its result exactly three cycles later with a valid flag. There is no back-pressure. The tables are loaded through a direct-address write port that selects channel, table and entry. The segment decision is an enumerated selector with four named outcomes. SUPER is used for inputs below 8/2^18, FINE below 1/128, COARSE below 1.0, and CLAMP at 1.0 and above. Each input moves to exactly one outcome per cycle, decided only by its magnitude.

Top module: `mseg_gamma`

## Requirements
- R1: While rst_n is low and after reset release, until the first valid result, out_valid is 0 and out_pix is all zeros.
- R2: out_valid equals in_valid from exactly three clock edges earlier. Back-to-back inputs give back-to-back results, and a single-cycle pulse gives a single-cycle result.
- R3: An input x (unsigned, 1 integer bit and 18 fraction bits) with x < 8 yields the superfine point x unchanged. Superfine points are written with wr_seg=0 at wr_addr 0..8.
- R4: For 8 <= x < 2048, with k = x>>3 and f = x&7, the lower point is fine point k and the upper point is fine point k+1. Fine point k is written with wr_seg=1 at wr_addr k-1. The output is lo + floor(((hi-lo)*f + 4)/8).
- R5: For 2048 <= x < 2^18, with k = x>>10 and w = x&1023, lo is coarse point k (wr_seg=2, wr_addr k). hi is coarse point k+1, or the channel maximum when k = 255. The output is lo + floor(((hi-lo)*w + 512)/1024).
- R6: An input with x >= 2^18 (bit 18 set) yields the channel's maximum register, which is written with wr_seg=2'd3.
- R7: Every result lies between its lower and upper neighbouring points inclusive, including when the curve falls between them.
- R8: While out_valid is 0, out_pix holds the last result unchanged.
- R9: Each channel (channel c occupies in_pix and out_pix bits [19c+18:19c] and [16c+15:16c]) uses only its own tables and maximum register, selected on writes by wr_ch = c.
- R10: A table write takes effect for every evaluation issued after the write cycle, and rewriting a single point changes results that use that point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Table write strobe |
| wr_ch | input | 2 | Channel selected by a write |
| wr_seg | input | 2 | Table selected by a write: 0 superfine, 1 fine, 2 coarse, 3 maximum |
| wr_addr | input | 8 | Entry index inside the selected table |
| wr_data | input | 16 | Point value written |
| in_valid | input | 1 | Input pixel is present this cycle |
| in_pix | input | 57 | Three 19-bit channel inputs, channel 0 in the low bits |
| out_valid | output | 1 | Result pixel is present this cycle |
| out_pix | output | 48 | Three 16-bit channel results, channel 0 in the low bits |

## Verification
Two functions can meet in the same cycle. In one, a lane's last coarse interval borrows the maximum register as its upper neighbour. In another, a different lane clamps straight to its own maximum. A single pulse sets one channel just above 255/256 and the other two at or beyond 1.0. This is done right after one channel's maximum was rewritten. Each channel is judged against a model that blends or clamps with its own maximum only. A wrong cross-lane or stale maximum shows up as a mismatch in that one channel.

// File: rtl/mseg_gamma_pkg.sv
package mseg_gamma_pkg;

    // Outcome of the per-input segment decision
    typedef enum logic [1:0] {
        SEG_SUPER  = 2'd0,
        SEG_FINE   = 2'd1,
        SEG_COARSE = 2'd2,
        SEG_CLAMP  = 2'd3
    } seg_e;

    // Table targeted by the write port
    typedef enum logic [1:0] {
        TBL_SUPER  = 2'd0,
        TBL_FINE   = 2'd1,
        TBL_COARSE = 2'd2,
        TBL_MAX    = 2'd3
    } tbl_e;

endpackage

// File: rtl/mseg_gamma_sel.sv
// Stage 1: segment decision, table address and normalized blend weight.
module mseg_gamma_sel
    import mseg_gamma_pkg::*;
#(
    parameter int FRAC_W  = 18,
    parameter int SF_BITS = 3,
    parameter int IDX_W   = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic [FRAC_W:0]      x,
    output seg_e                 seg_q,
    output logic [IDX_W-1:0]     addr_q,
    output logic [FRAC_W-IDX_W-1:0] wgt_q
);
    localparam int IN_W     = FRAC_W + 1;
    localparam int WGT_W    = FRAC_W - IDX_W;
    localparam int SF_LIM   = 1 << SF_BITS;
    localparam int FINE_LIM = 1 << (SF_BITS + IDX_W);

    seg_e             seg_d;
    logic [IDX_W-1:0] addr_d;
    logic [WGT_W-1:0] wgt_d;

    always_comb begin
        if (x[FRAC_W])
            seg_d = SEG_CLAMP;
        else if (x < IN_W'(SF_LIM))
            seg_d = SEG_SUPER;
        else if (x < IN_W'(FINE_LIM))
            seg_d = SEG_FINE;
        else
            seg_d = SEG_COARSE;
    end

    always_comb begin
        unique case (seg_d)
            SEG_SUPER: begin
                addr_d = IDX_W'(x[SF_BITS-1:0]);
                wgt_d  = '0;
            end
            SEG_FINE: begin
                // fine point k lives at table entry k-1
                addr_d = x[SF_BITS+IDX_W-1:SF_BITS] - IDX_W'(1);
                wgt_d  = {x[SF_BITS-1:0], {(WGT_W-SF_BITS){1'b0}}};
            end
            SEG_COARSE: begin
                addr_d = x[FRAC_W-1:WGT_W];
                wgt_d  = x[WGT_W-1:0];
            end
            SEG_CLAMP: begin
                addr_d = '0;
                wgt_d  = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seg_q  <= SEG_SUPER;
            addr_q <= '0;
            wgt_q  <= '0;
        end else if (en) begin
            seg_q  <= seg_d;
            addr_q <= addr_d;
            wgt_q  <= wgt_d;
        end
    end

endmodule

// File: rtl/mseg_gamma_tbl.sv
// Stage 2: per-lane point storage and the two-neighbour fetch.
module mseg_gamma_tbl
    import mseg_gamma_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int SF_BITS = 3,
    parameter int IDX_W   = 8,
    parameter int WGT_W   = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  tbl_e              wr_tbl,
    input  logic [IDX_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  seg_e              rd_seg,
    input  logic [IDX_W-1:0]  rd_addr,
    input  logic [WGT_W-1:0]  rd_wgt,
    output logic [DATA_W-1:0] lo_q,
    output logic [DATA_W-1:0] hi_q,
    output logic [WGT_W-1:0]  wgt_q
);
    localparam int SF_PTS = (1 << SF_BITS) + 1;
    localparam int N_PTS  = 1 << IDX_W;
    localparam int SFA_W  = SF_BITS + 1;

    logic [DATA_W-1:0] sf_mem     [SF_PTS];
    logic [DATA_W-1:0] fine_mem   [N_PTS];
    logic [DATA_W-1:0] coarse_mem [N_PTS];
    logic [DATA_W-1:0] max_q;

    logic [SFA_W-1:0]  sf_i, sf_n;
    logic [IDX_W-1:0]  a_nx;
    logic [DATA_W-1:0] lo_d, hi_d;

    // point storage, written one entry per cycle
    always_ff @(posedge clk) begin
        if (wr_en) begin
            unique case (wr_tbl)
                TBL_SUPER:  if (wr_addr < IDX_W'(SF_PTS))
                                sf_mem[wr_addr[SFA_W-1:0]] <= wr_data;
                TBL_FINE:   fine_mem[wr_addr]   <= wr_data;
                TBL_COARSE: coarse_mem[wr_addr] <= wr_data;
                TBL_MAX:    ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            max_q <= '1;
        else if (wr_en && wr_tbl == TBL_MAX)
            max_q <= wr_data;
    end

    always_comb begin
        sf_i = SFA_W'(rd_addr[SF_BITS-1:0]);
        sf_n = sf_i + SFA_W'(1);
        a_nx = rd_addr + IDX_W'(1);
        unique case (rd_seg)
            SEG_SUPER: begin
                lo_d = sf_mem[sf_i];
                hi_d = sf_mem[sf_n];
            end
            SEG_FINE: begin
                lo_d = fine_mem[rd_addr];
                hi_d = fine_mem[a_nx];
            end
            SEG_COARSE: begin
                lo_d = coarse_mem[rd_addr];
                hi_d = (&rd_addr) ? max_q : coarse_mem[a_nx];
            end
            SEG_CLAMP: begin
                lo_d = max_q;
                hi_d = max_q;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q  <= '0;
            hi_q  <= '0;
            wgt_q <= '0;
        end else if (rd_en) begin
            lo_q  <= lo_d;
            hi_q  <= hi_d;
            wgt_q <= rd_wgt;
        end
    end

endmodule

// File: rtl/mseg_gamma_mix.sv
// Stage 3: signed blend of two points, round half up, clamp to range.
module mseg_gamma_mix #(
    parameter int DATA_W = 16,
    parameter int WGT_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [DATA_W-1:0] lo,
    input  logic [DATA_W-1:0] hi,
    input  logic [WGT_W-1:0]  wgt,
    output logic [DATA_W-1:0] y_q
);
    localparam int D_W = DATA_W + 1;
    localparam int P_W = D_W + WGT_W + 1;
    localparam int S_W = DATA_W + 2;
    localparam logic signed [P_W-1:0] RND  = P_W'(1 << (WGT_W - 1));
    localparam logic signed [S_W-1:0] YMAX = S_W'((1 << DATA_W) - 1);

    logic signed [D_W-1:0] diff;
    logic signed [P_W-1:0] prod, step;
    logic signed [S_W-1:0] sum;
    logic [DATA_W-1:0]     y_d;

    always_comb begin
        diff = $signed({1'b0, hi}) - $signed({1'b0, lo});
        prod = P_W'(diff) * $signed({1'b0, wgt});
        step = (prod + RND) >>> WGT_W;
        sum  = $signed({2'b00, lo}) + S_W'(step);
        if (sum < 0)
            y_d = '0;
        else if (sum > YMAX)
            y_d = '1;
        else
            y_d = sum[DATA_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            y_q <= '0;
        else if (en)
            y_q <= y_d;
    end

endmodule

// File: rtl/mseg_gamma_lane.sv
// One channel: decision, fetch and blend with its own valid pipeline.
module mseg_gamma_lane
    import mseg_gamma_pkg::*;
#(
    parameter int FRAC_W  = 18,
    parameter int DATA_W  = 16,
    parameter int SF_BITS = 3,
    parameter int IDX_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  tbl_e              wr_tbl,
    input  logic [IDX_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              in_valid,
    input  logic [FRAC_W:0]   in_x,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_y
);
    localparam int WGT_W = FRAC_W - IDX_W;

    seg_e              s1_seg;
    logic [IDX_W-1:0]  s1_addr;
    logic [WGT_W-1:0]  s1_wgt;
    logic              s1_vld, s2_vld;
    logic [DATA_W-1:0] s2_lo, s2_hi;
    logic [WGT_W-1:0]  s2_wgt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_vld    <= 1'b0;
            s2_vld    <= 1'b0;
            out_valid <= 1'b0;
        end else begin
            s1_vld    <= in_valid;
            s2_vld    <= s1_vld;
            out_valid <= s2_vld;
        end
    end

    mseg_gamma_sel #(
        .FRAC_W (FRAC_W),
        .SF_BITS(SF_BITS),
        .IDX_W  (IDX_W)
    ) sel_i (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (in_valid),
        .x     (in_x),
        .seg_q (s1_seg),
        .addr_q(s1_addr),
        .wgt_q (s1_wgt)
    );

    mseg_gamma_tbl #(
        .DATA_W (DATA_W),
        .SF_BITS(SF_BITS),
        .IDX_W  (IDX_W),
        .WGT_W  (WGT_W)
    ) tbl_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_tbl (wr_tbl),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .rd_en  (s1_vld),
        .rd_seg (s1_seg),
        .rd_addr(s1_addr),
        .rd_wgt (s1_wgt),
        .lo_q   (s2_lo),
        .hi_q   (s2_hi),
        .wgt_q  (s2_wgt)
    );

    mseg_gamma_mix #(
        .DATA_W(DATA_W),
        .WGT_W (WGT_W)
    ) mix_i (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (s2_vld),
        .lo   (s2_lo),
        .hi   (s2_hi),
        .wgt  (s2_wgt),
        .y_q  (out_y)
    );

endmodule

// File: rtl/mseg_gamma.sv
module mseg_gamma
    import mseg_gamma_pkg::*;
#(
    parameter int NCH     = 3,
    parameter int FRAC_W  = 18,
    parameter int DATA_W  = 16,
    parameter int SF_BITS = 3,
    parameter int IDX_W   = 8,
    localparam int IN_W   = FRAC_W + 1,
    localparam int CH_W   = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [CH_W-1:0]        wr_ch,
    input  logic [1:0]             wr_seg,
    input  logic [IDX_W-1:0]       wr_addr,
    input  logic [DATA_W-1:0]      wr_data,
    input  logic                   in_valid,
    input  logic [NCH*IN_W-1:0]    in_pix,
    output logic                   out_valid,
    output logic [NCH*DATA_W-1:0]  out_pix
);
    logic [NCH-1:0] lane_vld;
    tbl_e           wr_tbl;

    assign wr_tbl    = tbl_e'(wr_seg);
    assign out_valid = &lane_vld;

    for (genvar g = 0; g < NCH; g++) begin : g_lane
        mseg_gamma_lane #(
            .FRAC_W (FRAC_W),
            .DATA_W (DATA_W),
            .SF_BITS(SF_BITS),
            .IDX_W  (IDX_W)
        ) lane_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr_en && (wr_ch == CH_W'(g))),
            .wr_tbl   (wr_tbl),
            .wr_addr  (wr_addr),
            .wr_data  (wr_data),
            .in_valid (in_valid),
            .in_x     (in_pix[g*IN_W +: IN_W]),
            .out_valid(lane_vld[g]),
            .out_y    (out_pix[g*DATA_W +: DATA_W])
        );
    end

endmodule

// File: rtl/mseg_gamma_chk.sv
module mseg_gamma_chk
    import mseg_gamma_pkg::*;
#(
    parameter int FRAC_W  = 18,
    parameter int DATA_W  = 16,
    parameter int SF_BITS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [FRAC_W:0]   in_x,
    input  logic              s1_vld,
    input  seg_e              s1_seg,
    input  logic              s2_vld,
    input  logic [DATA_W-1:0] s2_lo,
    input  logic [DATA_W-1:0] s2_hi,
    input  logic              out_valid,
    input  logic [DATA_W-1:0] out_y
);
    localparam int IN_W   = FRAC_W + 1;
    localparam int SF_LIM = 1 << SF_BITS;

    logic [1:0] cyc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cyc <= '0;
        else if (cyc != 2'd3)
            cyc <= cyc + 2'd1;
    end

    // R2: result flag trails the input flag by three edges
    a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == 2'd3) |-> (out_valid == $past(in_valid, 3)));

    // R3: superfine outcome only for inputs below the superfine limit
    a_r3_super_range: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc != 2'd0 && s1_vld && s1_seg == SEG_SUPER) |-> ($past(in_x) < IN_W'(SF_LIM)));

    // R6: inputs at or above 1.0 take the clamp outcome
    a_r6_clamp_sel: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc != 2'd0 && s1_vld && $past(in_x[FRAC_W])) |-> (s1_seg == SEG_CLAMP));

    // R7: blended result stays between the fetched neighbours
    a_r7_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        s2_vld |=> ((out_y >= (($past(s2_lo) < $past(s2_hi)) ? $past(s2_lo) : $past(s2_hi))) &&
                    (out_y <= (($past(s2_lo) < $past(s2_hi)) ? $past(s2_hi) : $past(s2_lo)))));

    // R8: result held while no valid result is presented
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc != 2'd0 && !out_valid) |-> $stable(out_y));

endmodule

bind mseg_gamma_lane mseg_gamma_chk #(
    .FRAC_W (FRAC_W),
    .DATA_W (DATA_W),
    .SF_BITS(SF_BITS)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_x     (in_x),
    .s1_vld   (s1_vld),
    .s1_seg   (s1_seg),
    .s2_vld   (s2_vld),
    .s2_lo    (s2_lo),
    .s2_hi    (s2_hi),
    .out_valid(out_valid),
    .out_y    (out_y)
);

// File: tb/mseg_gamma_tb_top.sv
`timescale 1ns/1ps
module mseg_gamma_tb_top;
    localparam int NCH = 3;
    localparam int IW  = 19;
    localparam int DW  = 16;
    localparam int NV  = 20;
    localparam int ONE = 1 << 18;

    localparam logic [IW-1:0] VEC [NV] = '{
        19'd0, 19'd1, 19'd7, 19'd8, 19'd9, 19'd15, 19'd100, 19'd2047,
        19'd2048, 19'd2049, 19'd3000, 19'd12345, 19'd65535, 19'd100000,
        19'd200000, 19'd261120, 19'd262143, 19'd262144, 19'd300000, 19'd524287
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [1:0]        wr_ch = '0;
    logic [1:0]        wr_seg = '0;
    logic [7:0]        wr_addr = '0;
    logic [15:0]       wr_data = '0;
    logic              in_valid = 1'b0;
    logic [NCH*IW-1:0] in_pix = '0;
    logic              out_valid;
    logic [NCH*DW-1:0] out_pix;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    int mx_cur [NCH];
    int fine_ovr_c = -1, fine_ovr_k = 0, fine_ovr_v = 0;
    int crs_ovr_c = -1, crs_ovr_k = 0, crs_ovr_v = 0;

    always #2.5 clk = ~clk;

    mseg_gamma dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ch(wr_ch), .wr_seg(wr_seg),
        .wr_addr(wr_addr), .wr_data(wr_data), .in_valid(in_valid), .in_pix(in_pix),
        .out_valid(out_valid), .out_pix(out_pix)
    );

    function automatic int sf_val(int c, int i);
        return (i * 9001 + c * 313 + 17) & 16'hFFFF;
    endfunction
    function automatic int fn_val(int c, int k);
        if (c == fine_ovr_c && k == fine_ovr_k) return fine_ovr_v;
        return (k * 7919 + c * 4001) & 16'hFFFF;
    endfunction
    function automatic int cr_val(int c, int k);
        if (c == crs_ovr_c && k == crs_ovr_k) return crs_ovr_v;
        return (k * 40503 + c * 1237) & 16'hFFFF;
    endfunction

    // independent curve model from the requirements
    function automatic void model(int c, int x, output int lo, output int hi, output int y);
        int k, f, d;
        if (x >= ONE) begin
            lo = mx_cur[c]; hi = lo; y = lo;
        end else if (x < 8) begin
            lo = sf_val(c, x); hi = lo; y = lo;
        end else if (x < 2048) begin
            k = x >> 3; f = x & 7;
            lo = fn_val(c, k); hi = fn_val(c, k + 1);
            d = hi - lo;
            y = lo + ((d * f + 4) >>> 3);
        end else begin
            k = x >> 10; f = x & 1023;
            lo = cr_val(c, k); hi = (k == 255) ? mx_cur[c] : cr_val(c, k + 1);
            d = hi - lo;
            y = lo + ((d * f + 512) >>> 10);
        end
    endfunction

    function automatic string rq(int x);
        if (x >= ONE) return "R6";
        if (x < 8) return "R3";
        if (x < 2048) return "R4";
        return "R5";
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(int c, int seg, int a, int d);
        @(negedge clk);
        wr_en = 1'b1; wr_ch = 2'(c); wr_seg = 2'(seg); wr_addr = 8'(a); wr_data = 16'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic int lane_x(int j, int c);
        return int'(VEC[(j + c * 7) % NV]);
    endfunction

    task automatic check_out(int c, int x, string req);
        int lo, hi, y, act;
        model(c, x, lo, hi, y);
        act = int'(out_pix[c*DW +: DW]);
        chk(req, act, y);
        // R7: result lies between the neighbours
        chk("R7", int'(act >= ((lo < hi) ? lo : hi) && act <= ((lo < hi) ? hi : lo)), 1);
    endtask

    task automatic pulse(int x0, int x1, int x2, string r0, string r1, string r2);
        @(negedge clk);
        in_valid = 1'b1;
        in_pix = {IW'(x2), IW'(x1), IW'(x0)};
        @(negedge clk);
        in_valid = 1'b0;
        chk("R2", int'(out_valid), 0);
        @(negedge clk);
        chk("R2", int'(out_valid), 0);
        @(negedge clk);
        chk("R2", int'(out_valid), 1);
        check_out(0, x0, r0);
        check_out(1, x1, r1);
        check_out(2, x2, r2);
        @(negedge clk);
        chk("R2", int'(out_valid), 0);
    endtask

    initial begin
        int held;
        for (int c = 0; c < NCH; c++) mx_cur[c] = 16'hFF00 - c * 16;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", int'(out_valid), 0);
        chk("R1", int'(out_pix == '0), 1);
        rst_n = 1'b1;

        // R10: load all tables through the write port encodings
        for (int c = 0; c < NCH; c++) begin
            for (int i = 0; i < 9; i++) wr(c, 0, i, sf_val(c, i));
            for (int k = 1; k <= 256; k++) wr(c, 1, k - 1, fn_val(c, k));
            for (int k = 0; k < 256; k++) wr(c, 2, k, cr_val(c, k));
            wr(c, 3, 0, mx_cur[c]);
        end
        @(negedge clk);
        chk("R1", int'(out_valid), 0);
        chk("R1", int'(out_pix == '0), 1);

        // table-driven back-to-back stream
        for (int i = 0; i < NV + 3; i++) begin
            @(negedge clk);
            if (i >= 3) begin
                chk("R2", int'(out_valid), 1);
                for (int c = 0; c < NCH; c++) check_out(c, lane_x(i - 3, c), rq(lane_x(i - 3, c)));
            end
            if (i < NV) begin
                in_valid = 1'b1;
                in_pix = {IW'(lane_x(i, 2)), IW'(lane_x(i, 1)), IW'(lane_x(i, 0))};
            end else begin
                in_valid = 1'b0;
            end
        end

        // R8: output holds while idle, even with inputs wiggling
        held = int'(out_pix[DW-1:0]);
        in_pix = '1;
        repeat (4) begin
            @(negedge clk);
            chk("R8", int'(out_valid), 0);
            chk("R8", int'(out_pix[DW-1:0]), held);
        end

        // R9: rewrite channel 1 maximum only; ch1 uses it in its last coarse
        // interval while ch0 and ch2 clamp to their own maxima (R5, R6)
        wr(1, 3, 0, 16'h0042);
        mx_cur[1] = 16'h0042;
        pulse(ONE, 261632, ONE, "R9", "R9", "R9");
        pulse(524287, ONE, 262143, "R6", "R6", "R5");

        // R10: single-point rewrites take effect on the next evaluation
        wr(0, 1, 9, 16'hABCD);
        fine_ovr_c = 0; fine_ovr_k = 10; fine_ovr_v = 16'hABCD;
        wr(2, 2, 100, 0);
        crs_ovr_c = 2; crs_ovr_k = 100; crs_ovr_v = 0;
        pulse(80, 84, 100 * 1024, "R10", "R4", "R10");
        pulse(76, 7, 100 * 1024 + 700, "R10", "R3", "R10");

        // R1: reset again mid-life
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1", int'(out_valid), 0);
        chk("R1", int'(out_pix == '0), 1);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule